// File: doc/BRIEF.md
# Row Decoder with Spare-Row Repair

This block drives the wordlines of one memory sub-array. A row address picks a line from a bank of normal wordlines. A small table of repair entries lets spare rows stand in for rows that are known to be faulty. Each entry holds a row address and an enable bit. All entries compare against the incoming address in parallel. When an enabled entry matches, its spare wordline is driven and the normal line for that address stays low.

The repair table is filled through a load port after reset. It models fuses that are blown once. A sticky lock then freezes the table until the next reset. A status flag reports a table in which two enabled entries hold the same row. In that case the lowest-numbered entry takes the access. Every wordline output is registered, so a selection appears on the clock edge after the address is presented.

Top module: `rowRepairDecoder`

## Requirements
- R1: While reset is held and directly after it, every normal and spare wordline is low, `dupError` is low, all repair entries are disabled and the table is unlocked.
- R2: With `accessEn` high and no enabled entry matching `rowAddr`, the next cycle drives `normalWl[rowAddr]` alone and keeps every spare line low.
- R3: With `accessEn` high and an enabled entry k matching `rowAddr`, the next cycle drives `spareWl[k]` and keeps all normal wordlines low.
- R4: An entry whose enable bit is 0 never drives its spare line, even when its stored address equals `rowAddr`. The normal row is driven instead.
- R5: With `accessEn` low, every wordline is low in the next cycle, whatever the address.
- R6: When several enabled entries match, only the spare line with the lowest entry index is driven.
- R7: `dupError` is high in the cycle after the table holds two or more enabled entries with the same address. It is low otherwise, and disabled entries never count.
- R8: A pulse on `cfgWrite` stores `cfgAddr` and `cfgEnable` into entry `cfgIndex` (0 to 3). The new contents take effect for accesses from the next cycle on. An access in the write cycle itself still sees the old contents.
- R9: A pulse on `cfgLock` sets a lock that only reset clears. A write in the same cycle as the lock pulse still lands. Writes in any later cycle leave the table unchanged.
- R10: At most one wordline, normal or spare, is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accessEn | input | 1 | Access request for this cycle |
| rowAddr | input | 7 | Functional row address |
| cfgWrite | input | 1 | Load one repair entry |
| cfgIndex | input | 2 | Entry selected for loading |
| cfgAddr | input | 7 | Faulty row address to store |
| cfgEnable | input | 1 | Enable bit to store |
| cfgLock | input | 1 | Freeze the repair table |
| normalWl | output | 128 | Registered normal wordlines |
| spareWl | output | 4 | Registered spare wordlines |
| dupError | output | 1 | Two enabled entries share an address |

## Verification
The bench builds the block with its defaults: a 7-bit address, 128 normal rows and four spares. This size makes an exhaustive sweep of every normal row cheap. It also puts every spare index within reach, including the extreme rows 0 and 127. Duplicate pairs, a disabled entry shadowing a live row, a write that coincides with an access, and a write that coincides with the lock pulse are all driven directly. A behavioural model tracks the table and predicts every output on every clock.

// File: rtl/rowRepairPkg.sv
package rowRepairPkg;
  localparam int ROW_AW  = 7;
  localparam int SPARE_N = 4;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic [SPARE_N-1:0] entryWr;     // one-hot write select, already gated by the lock
    logic [ROW_AW-1:0]  wrAddr;
    logic               wrValid;
    logic               lookup;      // access this cycle
    logic [ROW_AW-1:0]  lookupAddr;
  } repairStrobes_t;
endpackage

// File: rtl/repairCtrl.sv
module repairCtrl
  import rowRepairPkg::*;
#(
  parameter int ADDR_W = ROW_AW,
  parameter int SPARES = SPARE_N,
  localparam int IDX_W = (SPARES > 1) ? $clog2(SPARES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessEn,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic              cfgWrite,
  input  logic [IDX_W-1:0]  cfgIndex,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgEnable,
  input  logic              cfgLock,
  output repairStrobes_t    strobes,
  output logic              locked
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) locked <= 1'b0;
    else       locked <= locked | cfgLock;
  end

  logic [SPARES-1:0] wrSel;
  for (genvar i = 0; i < SPARES; i++) begin : g_sel
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    assign wrSel[i] = cfgWrite && !locked && (cfgIndex == MY_IDX);
  end

  always_comb begin
    strobes.entryWr    = wrSel;
    strobes.wrAddr     = cfgAddr;
    strobes.wrValid    = cfgEnable;
    strobes.lookup     = accessEn;
    strobes.lookupAddr = rowAddr;
  end
endmodule

// File: rtl/repairDatapath.sv
module repairDatapath
  import rowRepairPkg::*;
#(
  parameter int ADDR_W = ROW_AW,
  parameter int SPARES = SPARE_N,
  localparam int ROWS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  repairStrobes_t    strobes,
  output logic [ROWS-1:0]   normalWl,
  output logic [SPARES-1:0] spareWl,
  output logic              dupError,
  output logic [SPARES-1:0] entryValid
);
  logic [ADDR_W-1:0] entryAddr [SPARES];
  logic [SPARES-1:0] hitVec;

  // Repair table plus one comparator per spare row.
  for (genvar i = 0; i < SPARES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryAddr[i]  <= '0;
        entryValid[i] <= 1'b0;
      end else if (strobes.entryWr[i]) begin
        entryAddr[i]  <= strobes.wrAddr;
        entryValid[i] <= strobes.wrValid;
      end
    end
    assign hitVec[i] = entryValid[i] && (entryAddr[i] == strobes.lookupAddr);
  end

  // Lowest-index hit wins: isolate the least significant set bit.
  logic [SPARES-1:0] hitFirst;
  logic              anyHit;
  assign hitFirst = hitVec & (~hitVec + SPARES'(1));
  assign anyHit   = |hitVec;

  // Normal row decode.
  logic [ROWS-1:0] rowDec;
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [ADDR_W-1:0] ROW_CODE = ADDR_W'(r);
    assign rowDec[r] = (strobes.lookupAddr == ROW_CODE);
  end

  // Duplicate programming among enabled entries.
  logic dupNow;
  always_comb begin
    dupNow = 1'b0;
    for (int i = 0; i < SPARES; i++) begin
      for (int j = i + 1; j < SPARES; j++) begin
        if (entryValid[i] && entryValid[j] && (entryAddr[i] == entryAddr[j]))
          dupNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normalWl <= '0;
      spareWl  <= '0;
      dupError <= 1'b0;
    end else begin
      normalWl <= (strobes.lookup && !anyHit) ? rowDec : '0;
      spareWl  <= strobes.lookup ? hitFirst : '0;
      dupError <= dupNow;
    end
  end
endmodule

// File: rtl/rowRepairDecoder.sv
module rowRepairDecoder
  import rowRepairPkg::*;
#(
  parameter int ADDR_W = ROW_AW,
  parameter int SPARES = SPARE_N,
  localparam int ROWS  = 1 << ADDR_W,
  localparam int IDX_W = (SPARES > 1) ? $clog2(SPARES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessEn,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic              cfgWrite,
  input  logic [IDX_W-1:0]  cfgIndex,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgEnable,
  input  logic              cfgLock,
  output logic [ROWS-1:0]   normalWl,
  output logic [SPARES-1:0] spareWl,
  output logic              dupError
);
  repairStrobes_t    strobes;
  logic              ctrlLocked;
  logic [SPARES-1:0] entryValid;

  repairCtrl #(.ADDR_W(ADDR_W), .SPARES(SPARES)) u_ctrl (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .rowAddr(rowAddr),
    .cfgWrite(cfgWrite), .cfgIndex(cfgIndex), .cfgAddr(cfgAddr),
    .cfgEnable(cfgEnable), .cfgLock(cfgLock),
    .strobes(strobes), .locked(ctrlLocked)
  );

  repairDatapath #(.ADDR_W(ADDR_W), .SPARES(SPARES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .normalWl(normalWl), .spareWl(spareWl), .dupError(dupError),
    .entryValid(entryValid)
  );
endmodule

// File: rtl/rowRepairChecker.sv
module rowRepairChecker
  import rowRepairPkg::*;
#(
  parameter int ROWS   = 1 << ROW_AW,
  parameter int SPARES = SPARE_N
) (
  input logic              clk,
  input logic              rstN,
  input logic              accessEn,
  input logic              cfgWrite,
  input logic [ROWS-1:0]   normalWl,
  input logic [SPARES-1:0] spareWl,
  input logic [SPARES-1:0] entryValid,
  input logic              ctrlLocked
);
  AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({normalWl, spareWl})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |=> ({normalWl, spareWl} == '0)); // R5

  AST_ACCESS_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    accessEn |=> ($countones({normalWl, spareWl}) == 1)); // R2

  AST_SPARE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    accessEn |=> ((spareWl & ~$past(entryValid)) == '0)); // R4

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlLocked && cfgWrite) |=> $stable(entryValid)); // R9
endmodule

bind rowRepairDecoder rowRepairChecker #(.ROWS(ROWS), .SPARES(SPARES)) u_chk (
  .clk(clk), .rstN(rstN), .accessEn(accessEn), .cfgWrite(cfgWrite),
  .normalWl(normalWl), .spareWl(spareWl), .entryValid(entryValid),
  .ctrlLocked(ctrlLocked)
);

// File: tb/rowRepairDecoder_test.sv
`timescale 1ns/1ps
module rowRepairDecoder_test;
  localparam int NROW = 128;
  localparam int NSP  = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic accessEn = 1'b0, cfgWrite = 1'b0, cfgEnable = 1'b0, cfgLock = 1'b0;
  logic [6:0] rowAddr = '0, cfgAddr = '0;
  logic [1:0] cfgIndex = '0;
  logic [NROW-1:0] normalWl;
  logic [NSP-1:0]  spareWl;
  logic dupError;

  rowRepairDecoder uut (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .rowAddr(rowAddr),
    .cfgWrite(cfgWrite), .cfgIndex(cfgIndex), .cfgAddr(cfgAddr),
    .cfgEnable(cfgEnable), .cfgLock(cfgLock),
    .normalWl(normalWl), .spareWl(spareWl), .dupError(dupError)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string curTag = "R1";
  string expTag = "R1";

  // Behavioural reference model.
  int  mAddr [NSP];
  bit  mEn   [NSP];
  bit  mLocked;
  logic [NROW-1:0] expNormal = '0;
  logic [NSP-1:0]  expSpare  = '0;
  logic            expDup    = 1'b0;

  always @(posedge clk or negedge rstN) begin
    int hit;
    bit dup;
    if (!rstN) begin
      for (int k = 0; k < NSP; k++) begin mAddr[k] = 0; mEn[k] = 0; end
      mLocked = 0;
      expNormal <= '0; expSpare <= '0; expDup <= 1'b0; expTag <= "R1";
    end else begin
      hit = -1;
      for (int k = 0; k < NSP; k++)
        if (hit < 0 && mEn[k] && mAddr[k] == int'(rowAddr)) hit = k;
      dup = 0;
      for (int i = 0; i < NSP; i++)
        for (int j = i + 1; j < NSP; j++)
          if (mEn[i] && mEn[j] && mAddr[i] == mAddr[j]) dup = 1;
      expNormal <= '0; expSpare <= '0;
      if (accessEn) begin
        if (hit >= 0) expSpare[hit] <= 1'b1;
        else          expNormal[rowAddr] <= 1'b1;
      end
      expDup <= dup;
      expTag <= curTag;
      if (cfgWrite && !mLocked) begin
        mAddr[cfgIndex] = int'(cfgAddr);
        mEn[cfgIndex]   = cfgEnable;
      end
      if (cfgLock) mLocked = 1;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (normalWl !== expNormal) begin
        fails++;
        $display("FAIL %s normalWl actual=%h expected=%h", expTag, normalWl, expNormal);
      end
      checks++;
      if (spareWl !== expSpare) begin
        fails++;
        $display("FAIL %s spareWl actual=%b expected=%b", expTag, spareWl, expSpare);
      end
      checks++;
      if (dupError !== expDup) begin
        fails++;
        $display("FAIL %s dupError actual=%b expected=%b", expTag, dupError, expDup);
      end
      checks++;
      if ($countones({normalWl, spareWl}) > 1) begin
        fails++;
        $display("FAIL R10 active lines actual=%0d expected<=1", $countones({normalWl, spareWl}));
      end
    end
  end

  task automatic cyc(input logic acc, input logic [6:0] a);
    accessEn = acc; rowAddr = a;
    @(negedge clk);
  endtask

  task automatic load(input logic [1:0] idx, input logic [6:0] ad, input logic en,
                      input logic lk, input logic acc, input logic [6:0] a);
    cfgWrite = 1'b1; cfgIndex = idx; cfgAddr = ad; cfgEnable = en; cfgLock = lk;
    accessEn = acc; rowAddr = a;
    @(negedge clk);
    cfgWrite = 1'b0; cfgLock = 1'b0;
  endtask

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(1'b0, 7'd0);
    cyc(1'b0, 7'd0);

    curTag = "R2";
    for (int a = 0; a < NROW; a++) cyc(1'b1, 7'(a));
    cyc(1'b1, 7'd127); cyc(1'b1, 7'd0);

    curTag = "R5";
    cyc(1'b0, 7'd33); cyc(1'b0, 7'd127); cyc(1'b1, 7'd5); cyc(1'b0, 7'd5);

    curTag = "R8";
    load(2'd0, 7'd5, 1'b1, 1'b0, 1'b1, 7'd5);   // same-cycle access sees old table
    cyc(1'b1, 7'd5);

    curTag = "R4";
    load(2'd1, 7'd9, 1'b0, 1'b0, 1'b0, 7'd0);
    cyc(1'b1, 7'd9); cyc(1'b1, 7'd9);

    curTag = "R3";
    load(2'd2, 7'd127, 1'b1, 1'b0, 1'b0, 7'd0);
    load(2'd3, 7'd0, 1'b1, 1'b0, 1'b0, 7'd0);
    cyc(1'b1, 7'd127); cyc(1'b1, 7'd0); cyc(1'b1, 7'd126); cyc(1'b1, 7'd5);
    cyc(1'b0, 7'd127);

    curTag = "R6";
    load(2'd1, 7'd5, 1'b1, 1'b0, 1'b0, 7'd0);
    cyc(1'b1, 7'd5);
    curTag = "R7";
    cyc(1'b0, 7'd0); cyc(1'b1, 7'd9);
    load(2'd0, 7'd5, 1'b0, 1'b0, 1'b0, 7'd0);   // disable entry 0
    cyc(1'b1, 7'd5); cyc(1'b0, 7'd0);
    load(2'd3, 7'd127, 1'b0, 1'b0, 1'b0, 7'd0); // disabled copy of entry 2
    cyc(1'b0, 7'd0); cyc(1'b1, 7'd127);

    curTag = "R9";
    load(2'd3, 7'd50, 1'b1, 1'b1, 1'b0, 7'd0);  // lands together with the lock
    cyc(1'b1, 7'd50);
    load(2'd3, 7'd60, 1'b1, 1'b0, 1'b0, 7'd0);  // ignored
    load(2'd1, 7'd50, 1'b1, 1'b0, 1'b0, 7'd0);  // ignored
    cyc(1'b1, 7'd60); cyc(1'b1, 7'd50); cyc(1'b1, 7'd5); cyc(1'b0, 7'd0);

    curTag = "R1";
    rstN = 1'b0;
    cyc(1'b1, 7'd50); cyc(1'b1, 7'd50);
    rstN = 1'b1;
    cyc(1'b1, 7'd50); cyc(1'b1, 7'd5);
    load(2'd2, 7'd77, 1'b1, 1'b0, 1'b0, 7'd0);  // unlocked again after reset
    cyc(1'b1, 7'd77); cyc(1'b0, 7'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule